// File: doc/BRIEF.md
# NAND Hamming Sector ECC Corrector

This block checks one 512-byte sector of NAND page data against the 3-byte Hamming code held in the spare area, and repairs a single flipped data bit in place. A start strobe hands it two codes: the one stored in flash and the one freshly computed while the sector streamed past. Each code is expanded into a 32-bit word in which the third byte is split into two nibbles. The block XORs the two words into a syndrome and counts the set bits in it over a short pipeline.

From the syndrome and its weight the block picks one of four outcomes. A zero syndrome is clean. A weight of exactly twelve marks one correctable data bit, and the upper half of the syndrome gives its byte and bit address. A weight of one means the stored code itself is damaged. Any other weight is uncorrectable, with one exception: an erased page is reported clean. For a correctable error the block reads the target byte through a byte-wide port to the sector buffer. It waits for the read data, writes the byte back with the addressed bit inverted, and then reports.

Top module: `nand_ham_fix`

## Requirements
- R1: A 24-bit code carries byte0 in bits 7:0, byte1 in bits 15:8 and byte2 in bits 23:16. It expands to 32 bits as follows: byte0 goes to 7:0, byte1 to 23:16, the low nibble of byte2 to 11:8 and the high nibble of byte2 to 27:24. All other bits are zero. The syndrome is the XOR of the two expanded codes.
- R2: A zero syndrome ends with status 2'b00 (clean), and the sector buffer is not read or written.
- R3: A syndrome with exactly 12 set bits ends with status 2'b01 (corrected). err_byte equals syndrome bits 27:19 and err_bit equals syndrome bits 18:16. Exactly that one bit of that one buffer byte is inverted.
- R4: A correction issues exactly one read of the target byte. Its single write is issued only in a cycle where buf_rd_valid returns that byte, whatever the buffer read latency. Read and write are never asserted together.
- R5: A syndrome with exactly 1 set bit ends with status 2'b10 (stored ECC corrupted), and the buffer is not written.
- R6: Any other nonzero syndrome weight ends with status 2'b11 (uncorrectable), and the buffer is not written.
- R7: An expanded stored code of 0x0FFF0FFF with an all-zero computed code is an erased page and ends with status 2'b00 instead of 2'b11.
- R8: done is a one-cycle pulse. status, err_byte and err_bit keep their values from that pulse until the next accepted start.
- R9: A start that arrives while an operation is in progress is ignored. It produces no second done pulse and does not change the result.
- R10: After reset the block is idle with done low, status 2'b00 and no buffer read or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a check with the codes presented this cycle |
| stored_ecc | input | 24 | Code read from the spare area (byte2,byte1,byte0) |
| calc_ecc | input | 24 | Code computed over the sector data (byte2,byte1,byte0) |
| buf_rd_valid | input | 1 | Sector buffer returns read data |
| buf_rd_data | input | 8 | Read data from the sector buffer |
| buf_rd_en | output | 1 | Read request to the sector buffer |
| buf_addr | output | 9 | Byte address for read and write |
| buf_wr_en | output | 1 | Write request to the sector buffer |
| buf_wr_data | output | 8 | Corrected byte to write |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 clean, 01 corrected, 10 ECC corrupted, 11 uncorrectable |
| err_byte | output | 9 | Byte index of the corrected bit (zero otherwise) |
| err_bit | output | 3 | Bit index of the corrected bit (zero otherwise) |

## Verification
The bench places corrections at byte 0 bit 0, byte 511 bit 7 and a mid-sector address whose index spans both halves of the split third byte. A wrong nibble placement would therefore hit the wrong byte, and the bench would see a changed neighbour and an unchanged target. The buffer model returns data two cycles after a read, so a design that writes on a guessed latency stores stale or wrong data. The erased page is paired with a near-erased code that differs by one bit. A design that compares only part of the pattern would report that code clean as well. A second start during a busy correction checks that the result and the done count stay those of the first request.

// File: rtl/ham_fix_pkg.sv
package ham_fix_pkg;
  localparam int CODE_W       = 24;
  localparam int SYN_W        = 32;
  localparam int IDX_W        = 9;
  localparam int BIT_W        = 3;
  localparam int DATA_W       = 8;
  localparam int WEIGHT_W     = $clog2(SYN_W + 1);
  localparam int FIX_WEIGHT   = 12;
  localparam int BADECC_WEIGHT = 1;
  localparam logic [SYN_W-1:0] ERASED_WORD = 32'h0FFF_0FFF;

  typedef enum logic [1:0] {
    ST_CLEAN   = 2'b00,
    ST_FIXED   = 2'b01,
    ST_BAD_ECC = 2'b10,
    ST_UNCORR  = 2'b11
  } fix_status_e;

  typedef enum logic [2:0] {
    F_IDLE, F_SYN, F_CLS, F_RD, F_WAIT
  } fix_state_e;

  // Byte2 is split: low nibble to 11:8, high nibble to 27:24.
  function automatic logic [SYN_W-1:0] expand_code(input logic [CODE_W-1:0] c);
    expand_code = {4'h0, c[23:20], c[15:8], 4'h0, c[19:16], c[7:0]};
  endfunction
endpackage

// File: rtl/ham_syndrome.sv
module ham_syndrome
  import ham_fix_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] stored_ecc,
  input  logic [CODE_W-1:0] calc_ecc,
  output logic [SYN_W-1:0]  syn_q,
  output logic              erased_q
);
  logic [SYN_W-1:0] stored_x, calc_x, syn_d;
  logic             erased_d;

  always_comb begin
    stored_x = expand_code(stored_ecc);
    calc_x   = expand_code(calc_ecc);
    syn_d    = stored_x ^ calc_x;
    erased_d = (stored_x == ERASED_WORD) && (calc_x == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syn_q    <= '0;
      erased_q <= 1'b0;
    end else if (load) begin
      syn_q    <= syn_d;
      erased_q <= erased_d;
    end
  end
endmodule

// File: rtl/ham_popcnt.sv
module ham_popcnt #(
  parameter int W    = 32,
  parameter int LANE = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [W-1:0]           vec,
  output logic [$clog2(W+1)-1:0] total
);
  localparam int NL = W / LANE;
  localparam int PW = $clog2(LANE + 1);
  localparam int TW = $clog2(W + 1);

  logic [NL*PW-1:0] part_w;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [PW-1:0] lane_d, lane_q;
    always_comb begin
      lane_d = '0;
      for (int b = 0; b < LANE; b++) lane_d = lane_d + PW'(vec[g*LANE+b]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  lane_q <= '0;
      else if (en) lane_q <= lane_d;
    end
    assign part_w[g*PW +: PW] = lane_q;
  end

  always_comb begin
    total = '0;
    for (int g = 0; g < NL; g++) total = total + TW'(part_w[g*PW +: PW]);
  end
endmodule

// File: rtl/ham_fix_ctrl.sv
module ham_fix_ctrl
  import ham_fix_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SYN_W-1:0]    syn,
  input  logic                erased,
  input  logic [WEIGHT_W-1:0] weight,
  input  logic                buf_rd_valid,
  input  logic [DATA_W-1:0]   buf_rd_data,
  output logic                syn_load,
  output logic                cnt_en,
  output logic                buf_rd_en,
  output logic [IDX_W-1:0]    buf_addr,
  output logic                buf_wr_en,
  output logic [DATA_W-1:0]   buf_wr_data,
  output logic                done,
  output logic [1:0]          status,
  output logic [IDX_W-1:0]    err_byte,
  output logic [BIT_W-1:0]    err_bit
);
  fix_state_e  state_q, state_d;
  fix_status_e status_q, status_d, kind;
  logic        done_q, done_d;
  logic [IDX_W-1:0] byte_q, byte_d;
  logic [BIT_W-1:0] bit_q, bit_d;

  always_comb begin
    if (syn == '0)                           kind = ST_CLEAN;
    else if (weight == WEIGHT_W'(FIX_WEIGHT))    kind = ST_FIXED;
    else if (weight == WEIGHT_W'(BADECC_WEIGHT)) kind = ST_BAD_ECC;
    else if (erased)                         kind = ST_CLEAN;
    else                                     kind = ST_UNCORR;
  end

  always_comb begin
    state_d  = state_q;
    status_d = status_q;
    done_d   = 1'b0;
    byte_d   = byte_q;
    bit_d    = bit_q;
    case (state_q)
      F_IDLE: if (start) state_d = F_SYN;
      F_SYN:  state_d = F_CLS;
      F_CLS: begin
        if (kind == ST_FIXED) begin
          byte_d  = syn[27:19];
          bit_d   = syn[18:16];
          state_d = F_RD;
        end else begin
          byte_d   = '0;
          bit_d    = '0;
          status_d = kind;
          done_d   = 1'b1;
          state_d  = F_IDLE;
        end
      end
      F_RD:   state_d = F_WAIT;
      F_WAIT: if (buf_rd_valid) begin
        status_d = ST_FIXED;
        done_d   = 1'b1;
        state_d  = F_IDLE;
      end
      default: state_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= F_IDLE;
      status_q <= ST_CLEAN;
      done_q   <= 1'b0;
      byte_q   <= '0;
      bit_q    <= '0;
    end else begin
      state_q  <= state_d;
      status_q <= status_d;
      done_q   <= done_d;
      byte_q   <= byte_d;
      bit_q    <= bit_d;
    end
  end

  assign syn_load    = start && (state_q == F_IDLE);
  assign cnt_en      = (state_q == F_SYN);
  assign buf_rd_en   = (state_q == F_RD);
  assign buf_wr_en   = (state_q == F_WAIT) && buf_rd_valid;
  assign buf_addr    = byte_q;
  assign buf_wr_data = buf_rd_data ^ (DATA_W'(1) << bit_q);
  assign done        = done_q;
  assign status      = status_q;
  assign err_byte    = byte_q;
  assign err_bit     = bit_q;

  // R4: the write carries returned read data and never overlaps a read
  assert_wr_after_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |-> buf_rd_valid);
  assert_single_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_rd_en && buf_wr_en));
  // R3: a write is followed by a corrected report
  assert_wr_reports_fix_R3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |=> (done && status == ST_FIXED));
  // R8: done is a single-cycle pulse and status moves only with it
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status) |-> done);
  // R9: a busy start does not restart the pipeline
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state_q != F_IDLE) |=> (state_q != F_SYN));
endmodule

// File: rtl/nand_ham_fix.sv
module nand_ham_fix
  import ham_fix_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] stored_ecc,
  input  logic [CODE_W-1:0] calc_ecc,
  input  logic              buf_rd_valid,
  input  logic [DATA_W-1:0] buf_rd_data,
  output logic              buf_rd_en,
  output logic [IDX_W-1:0]  buf_addr,
  output logic              buf_wr_en,
  output logic [DATA_W-1:0] buf_wr_data,
  output logic              done,
  output logic [1:0]        status,
  output logic [IDX_W-1:0]  err_byte,
  output logic [BIT_W-1:0]  err_bit
);
  logic [SYN_W-1:0]    syn;
  logic                erased, syn_load, cnt_en;
  logic [WEIGHT_W-1:0] weight;

  ham_syndrome u_syn (
    .clk(clk), .rst_n(rst_n), .load(syn_load),
    .stored_ecc(stored_ecc), .calc_ecc(calc_ecc),
    .syn_q(syn), .erased_q(erased)
  );

  ham_popcnt #(.W(SYN_W), .LANE(8)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cnt_en), .vec(syn), .total(weight)
  );

  ham_fix_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .syn(syn), .erased(erased), .weight(weight),
    .buf_rd_valid(buf_rd_valid), .buf_rd_data(buf_rd_data),
    .syn_load(syn_load), .cnt_en(cnt_en),
    .buf_rd_en(buf_rd_en), .buf_addr(buf_addr),
    .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data),
    .done(done), .status(status), .err_byte(err_byte), .err_bit(err_bit)
  );
endmodule

// File: tb/nand_ham_fix_test.sv
module nand_ham_fix_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [23:0] stored_ecc = '0, calc_ecc = '0;
  logic buf_rd_valid, buf_rd_en, buf_wr_en, done;
  logic [7:0] buf_rd_data, buf_wr_data;
  logic [8:0] buf_addr, err_byte;
  logic [2:0] err_bit;
  logic [1:0] status;

  int checks = 0, errors = 0, cycles = 0;
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0;

  nand_ham_fix uut (.*);

  always #4 clk = ~clk;

  // Sector buffer model, read latency of two cycles
  logic [7:0] mem [512];
  logic       p1_v;
  logic [8:0] p1_a;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= 8'(i * 7 + 3);
      p1_v <= 1'b0; p1_a <= '0; buf_rd_valid <= 1'b0; buf_rd_data <= '0;
    end else begin
      p1_v <= buf_rd_en; p1_a <= buf_addr;
      buf_rd_valid <= p1_v;
      buf_rd_data  <= mem[p1_a];
      if (buf_wr_en) mem[buf_addr] <= buf_wr_data;
      if (buf_rd_en) rd_cnt <= rd_cnt + 1;
      if (buf_wr_en) wr_cnt <= wr_cnt + 1;
      if (done) done_cnt <= done_cnt + 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected under 20000)", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic logic [7:0] orig(input int a);
    return 8'(a * 7 + 3);
  endfunction

  // Pack a 32-bit syndrome back into the 24-bit code layout of R1
  function automatic logic [23:0] pack_syn(input logic [31:0] s);
    return {s[27:24], s[11:8], s[23:16], s[7:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [23:0] s, input logic [23:0] c);
    int n;
    @(negedge clk);
    stored_ecc = s; calc_ecc = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    check(done, "R8 done seen", int'(done), 1);
  endtask

  task automatic t_reset;
    check(done == 1'b0, "R10 done after reset", int'(done), 0);
    check(status == 2'b00, "R10 status after reset", int'(status), 0);
    check(!buf_rd_en && !buf_wr_en, "R10 no buffer access", int'({buf_rd_en, buf_wr_en}), 0);
  endtask

  task automatic t_clean;
    int w0 = wr_cnt, r0 = rd_cnt;
    run_op(24'hA5C3_3C, 24'hA5C3_3C);
    check(status == 2'b00, "R2 clean status", int'(status), 0);
    check(rd_cnt == r0 && wr_cnt == w0, "R2 no buffer access", rd_cnt - r0 + wr_cnt - w0, 0);
  endtask

  task automatic t_fix(input int byte_i, input int bit_i);
    logic [11:0] hi;
    logic [31:0] s;
    logic [23:0] base;
    int w0 = wr_cnt, r0 = rd_cnt, nb;
    hi = {9'(byte_i), 3'(bit_i)};
    s = {4'h0, hi, 4'h0, ~hi};
    base = 24'h5A3C96;
    nb = (byte_i == 511) ? 510 : byte_i + 1;
    run_op(base, base ^ pack_syn(s));
    check(status == 2'b01, "R3 corrected status", int'(status), 1);
    check(err_byte == 9'(byte_i), "R3 R1 byte index", int'(err_byte), byte_i);
    check(err_bit == 3'(bit_i), "R3 bit index", int'(err_bit), bit_i);
    check(mem[byte_i] == (orig(byte_i) ^ (8'd1 << bit_i)), "R3 target byte repaired",
          int'(mem[byte_i]), int'(orig(byte_i) ^ (8'd1 << bit_i)));
    check(mem[nb] == orig(nb), "R3 neighbour untouched", int'(mem[nb]), int'(orig(nb)));
    check(wr_cnt - w0 == 1 && rd_cnt - r0 == 1, "R4 one read one write",
          (rd_cnt - r0) * 16 + wr_cnt - w0, 17);
    mem[byte_i] = orig(byte_i);
  endtask

  task automatic t_bad_ecc;
    int w0 = wr_cnt;
    run_op(24'h123456, 24'h123456 ^ 24'h000400);
    check(status == 2'b10, "R5 ecc corrupted status", int'(status), 2);
    check(wr_cnt == w0, "R5 no write", wr_cnt - w0, 0);
  endtask

  task automatic t_uncorr;
    int w0 = wr_cnt;
    run_op(24'h123456, 24'h123456 ^ 24'h000003);
    check(status == 2'b11, "R6 uncorrectable status", int'(status), 3);
    check(wr_cnt == w0, "R6 no write", wr_cnt - w0, 0);
  endtask

  task automatic t_erased;
    run_op(24'hFFFFFF, 24'h000000);
    check(status == 2'b00, "R7 erased page clean", int'(status), 0);
    run_op(24'hFFFFFF, 24'h000001);
    check(status == 2'b11, "R7 near-erased is uncorrectable", int'(status), 3);
  endtask

  task automatic t_hold;
    logic [1:0] st;
    run_op(24'h123456, 24'h123456 ^ 24'h000400);
    st = status;
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", int'(done), 0);
    repeat (5) @(negedge clk);
    check(status == st, "R8 status held", int'(status), int'(st));
  endtask

  task automatic t_busy;
    logic [11:0] hi;
    logic [31:0] s;
    int d0, w0;
    int n;
    hi = {9'd77, 3'd5};
    s = {4'h0, hi, 4'h0, ~hi};
    @(negedge clk);
    d0 = done_cnt; w0 = wr_cnt;
    stored_ecc = 24'h0; calc_ecc = pack_syn(s); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    stored_ecc = 24'h111111; calc_ecc = 24'h111110; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    repeat (10) @(negedge clk);
    check(status == 2'b01 && err_byte == 9'd77, "R9 busy start ignored", int'(status), 1);
    check(done_cnt - d0 == 1, "R9 single done", done_cnt - d0, 1);
    check(wr_cnt - w0 == 1, "R9 single write", wr_cnt - w0, 1);
    mem[77] = orig(77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_fix(421, 3);
    t_fix(0, 0);
    t_fix(511, 7);
    t_bad_ecc();
    t_uncorr();
    t_erased();
    t_hold();
    t_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule